// File: doc/BRIEF.md
# Vertically-Crosswise 4x4 Unsigned Multiplier

This block multiplies two unsigned 4-bit operands and drives their 8-bit product with no clock and no storage. Each operand is split into a low and a high 2-bit half. Four small 2x2 cells form the four half-by-half products. The two cross terms of each cell are summed with half adders, so the cell needs no array.

Three 4-bit adders then merge the four 2x2 results into the full product. First the two cross results are added together. That sum is added to the middle slice formed from the low-by-low and high-by-high results. The last adder folds both carries into the top two product bits. A build-time parameter picks the adder circuit used in all three merge positions: a ripple chain, a generate/propagate lookahead network, or a ripple chain bypassed by a block-skip multiplexer. The product does not depend on that choice.

The block is meant to sit in a combinational datapath, where the surrounding logic registers its inputs and output as needed.

Top module: `vc_mul4x4`

## Requirements
- R1: With the ripple adder style (`ADD_RIPPLE`), `product` equals `a_op * b_op` for all 256 operand pairs.
- R2: With the lookahead adder style (`ADD_LOOKAHEAD`), `product` equals `a_op * b_op` for all 256 operand pairs. Carries come from generate (AND) and propagate (OR) terms together with the carry in.
- R3: With the skip adder style (`ADD_SKIP`), `product` equals `a_op * b_op` for all 256 operand pairs. Inside each adder, when every bit propagates (XOR of the operand bits is all ones), the carry out is the carry in.
- R4: Bit 0 of `product` equals `a_op[0] & b_op[0]`.
- R5: For 15 x 15 the product is 225. No carry is ever lost above bit 7.
- R6: When either operand is zero, `product` is zero.
- R7: The block is purely combinational. `product` reflects the current operands in the same evaluation, with no clock edge in between.
- R8: For every operand pair, the three adder styles give identical products.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_op | input | 4 | Unsigned multiplicand |
| b_op | input | 4 | Unsigned multiplier |
| product | output | 8 | Unsigned product a_op * b_op |

## Verification
Every result is due zero cycles after its stimulus, because no register lies on any path from an operand to the product. The bench applies each operand pair on a rising clock edge and samples all three style instances on the following falling edge, half a period later. This leaves ample time for the combinational network to settle while still showing that no edge was needed. Each pair is compared against a behavioural integer product, and the three instances are also compared with each other on that same sample.

// File: rtl/vc_mul_pkg.sv
package vc_mul_pkg;

    typedef enum logic [1:0] {
        ADD_RIPPLE    = 2'd0,
        ADD_LOOKAHEAD = 2'd1,
        ADD_SKIP      = 2'd2
    } adder_style_e;

endpackage

// File: rtl/vc_cell2.sv
module vc_cell2 (
    input  logic [1:0] x_in,
    input  logic [1:0] y_in,
    output logic [3:0] z_out
);
    logic vert_lo;
    logic cross_a;
    logic cross_b;
    logic vert_hi;
    logic mid_sum;
    logic mid_cry;
    logic top_sum;
    logic top_cry;

    always_comb begin
        vert_lo = x_in[0] & y_in[0];
        cross_a = x_in[1] & y_in[0];
        cross_b = x_in[0] & y_in[1];
        vert_hi = x_in[1] & y_in[1];
        // first half adder: crosswise terms
        mid_sum = cross_a ^ cross_b;
        mid_cry = cross_a & cross_b;
        // second half adder: vertical high term plus carry
        top_sum = vert_hi ^ mid_cry;
        top_cry = vert_hi & mid_cry;
        z_out   = {top_cry, top_sum, mid_sum, vert_lo};
    end

    logic [3:0] cell_ref;
    always_comb begin
        cell_ref = {2'b00, x_in} * {2'b00, y_in};
        // R4: each cell yields the true 2x2 product
        assert_cell_product_R4: assert (z_out == cell_ref)
            else $error("cell product mismatch");
    end
endmodule

// File: rtl/vc_add4.sv
module vc_add4
    import vc_mul_pkg::*;
#(
    parameter int           W     = 4,
    parameter adder_style_e STYLE = ADD_RIPPLE
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         c_in,
    output logic [W-1:0] sum,
    output logic         c_out
);
    localparam int CW = W + 1;

    logic [CW-1:0] chk;
    always_comb begin
        chk = {1'b0, op_a} + {1'b0, op_b} + {{W{1'b0}}, c_in};
    end

    generate
        if (STYLE == ADD_RIPPLE) begin : g_ripple
            logic [W:0] rc;
            assign rc[0] = c_in;
            for (genvar i = 0; i < W; i++) begin : g_fa
                assign sum[i]  = op_a[i] ^ op_b[i] ^ rc[i];
                assign rc[i+1] = (op_a[i] & op_b[i]) | (rc[i] & (op_a[i] ^ op_b[i]));
            end
            assign c_out = rc[W];
            always_comb begin
                assert_ripple_sum_R1: assert ({c_out, sum} == chk)
                    else $error("ripple adder mismatch");
            end
        end else if (STYLE == ADD_LOOKAHEAD) begin : g_cla
            logic [W-1:0] gen;
            logic [W-1:0] prp;
            logic [W:0]   lc;
            always_comb begin
                gen   = op_a & op_b;
                prp   = op_a | op_b;
                lc    = '0;
                lc[0] = c_in;
                for (int i = 0; i < W; i++) begin
                    logic acc;
                    logic run;
                    acc = 1'b0;
                    for (int j = 0; j <= i; j++) begin
                        run = gen[j];
                        for (int k = j + 1; k <= i; k++) begin
                            run = run & prp[k];
                        end
                        acc = acc | run;
                    end
                    run = c_in;
                    for (int k = 0; k <= i; k++) begin
                        run = run & prp[k];
                    end
                    lc[i+1] = acc | run;
                end
            end
            assign sum   = op_a ^ op_b ^ lc[W-1:0];
            assign c_out = lc[W];
            always_comb begin
                assert_cla_sum_R2: assert ({c_out, sum} == chk)
                    else $error("lookahead adder mismatch");
            end
        end else begin : g_skip
            logic [W-1:0] xp;
            logic [W:0]   sc;
            logic         all_prop;
            assign sc[0] = c_in;
            for (genvar i = 0; i < W; i++) begin : g_fa
                assign xp[i]   = op_a[i] ^ op_b[i];
                assign sum[i]  = xp[i] ^ sc[i];
                assign sc[i+1] = (op_a[i] & op_b[i]) | (sc[i] & xp[i]);
            end
            assign all_prop = &xp;
            assign c_out    = all_prop ? c_in : sc[W];
            always_comb begin
                assert_skip_sum_R3: assert ({c_out, sum} == chk)
                    else $error("skip adder mismatch");
                if (op_a == ~op_b) begin
                    assert_skip_bypass_R3: assert (c_out == c_in)
                        else $error("skip bypass carry wrong");
                end
            end
        end
    endgenerate
endmodule

// File: rtl/vc_mul4x4.sv
module vc_mul4x4
    import vc_mul_pkg::*;
#(
    parameter adder_style_e STYLE = ADD_RIPPLE
) (
    input  logic [3:0] a_op,
    input  logic [3:0] b_op,
    output logic [7:0] product
);
    localparam int OPW   = 4;
    localparam int HALFW = OPW / 2;
    localparam int PRW   = 2 * OPW;

    logic [HALFW-1:0] a_lo, a_hi, b_lo, b_hi;
    logic [OPW-1:0]   p_ll, p_hl, p_lh, p_hh;
    logic [OPW-1:0]   s_cross, s_mid, s_top;
    logic             c_cross, c_mid, c_top;
    logic [OPW-1:0]   mid_in, top_a, top_b;

    assign a_lo = a_op[HALFW-1:0];
    assign a_hi = a_op[OPW-1:HALFW];
    assign b_lo = b_op[HALFW-1:0];
    assign b_hi = b_op[OPW-1:HALFW];

    vc_cell2 u_ll (.x_in(a_lo), .y_in(b_lo), .z_out(p_ll));
    vc_cell2 u_hl (.x_in(a_hi), .y_in(b_lo), .z_out(p_hl));
    vc_cell2 u_lh (.x_in(a_lo), .y_in(b_hi), .z_out(p_lh));
    vc_cell2 u_hh (.x_in(a_hi), .y_in(b_hi), .z_out(p_hh));

    // stage 1: the two cross products, both weighted 2^HALFW
    vc_add4 #(.W(OPW), .STYLE(STYLE)) u_add_cross (
        .op_a(p_hl), .op_b(p_lh), .c_in(1'b0),
        .sum(s_cross), .c_out(c_cross)
    );

    // stage 2: add the slice {hh low, ll high}
    assign mid_in = {p_hh[HALFW-1:0], p_ll[OPW-1:HALFW]};
    vc_add4 #(.W(OPW), .STYLE(STYLE)) u_add_mid (
        .op_a(s_cross), .op_b(mid_in), .c_in(1'b0),
        .sum(s_mid), .c_out(c_mid)
    );

    // stage 3: fold both carries into the hh upper bits
    assign top_a = {{HALFW{1'b0}}, p_hh[OPW-1:HALFW]};
    assign top_b = {{(OPW-1){1'b0}}, c_cross};
    vc_add4 #(.W(OPW), .STYLE(STYLE)) u_add_top (
        .op_a(top_a), .op_b(top_b), .c_in(c_mid),
        .sum(s_top), .c_out(c_top)
    );

    assign product = {s_top[HALFW-1:0], s_mid, p_ll[HALFW-1:0]};

    logic [PRW-1:0] prod_ref;
    always_comb begin
        prod_ref = {4'b0000, a_op} * {4'b0000, b_op};
        // R8: every style gives the true product
        assert_product_R8: assert (product == prod_ref)
            else $error("product mismatch");
        // R5: nothing spills past the top product bit
        assert_no_overflow_R5: assert (s_top[OPW-1:HALFW] == '0 && !c_top)
            else $error("carry lost above product");
    end
endmodule

// File: tb/vc_mul4x4_tb.sv
module vc_mul4x4_tb;
    import vc_mul_pkg::*;

    logic       clk = 1'b0;
    logic [3:0] a_op = '0;
    logic [3:0] b_op = '0;
    logic [7:0] prod_rip, prod_cla, prod_skp;
    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    vc_mul4x4 #(.STYLE(ADD_RIPPLE))    u_dut      (.a_op(a_op), .b_op(b_op), .product(prod_rip));
    vc_mul4x4 #(.STYLE(ADD_LOOKAHEAD)) u_dut_cla  (.a_op(a_op), .b_op(b_op), .product(prod_cla));
    vc_mul4x4 #(.STYLE(ADD_SKIP))      u_dut_skip (.a_op(a_op), .b_op(b_op), .product(prod_skp));

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s a=%0d b=%0d got=%0d exp=%0d", req, a_op, b_op, got, exp);
        end
    endtask

    task automatic apply(input int av, input int bv);
        @(posedge clk);
        a_op = av[3:0];
        b_op = bv[3:0];
        @(negedge clk);
    endtask

    initial begin
        // reset-like start: zero operands give zero (R6)
        @(negedge clk);
        check("R6", prod_rip, 0);
        for (int av = 0; av < 16; av++) begin
            for (int bv = 0; bv < 16; bv++) begin
                int exp;
                apply(av, bv);
                exp = av * bv;
                check("R1", prod_rip, exp);
                check("R2", prod_cla, exp);
                check("R3", prod_skp, exp);
                check("R4", prod_rip[0], av % 2 * (bv % 2));
                check("R8", prod_cla, prod_rip);
                check("R8", prod_skp, prod_rip);
                if (av == 0 || bv == 0) check("R6", prod_skp, 0);
            end
        end
        apply(15, 15);
        check("R5", prod_rip, 225);
        check("R5", prod_cla, 225);
        check("R5", prod_skp, 225);
        // R7: operands change mid-cycle, result follows without a clock edge
        @(negedge clk);
        a_op = 4'd9;
        b_op = 4'd7;
        #1;
        check("R7", prod_rip, 63);
        check("R7", prod_skp, 63);
        a_op = 4'd12;
        #1;
        check("R7", prod_cla, 84);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule